// File: doc/BRIEF.md
# Outbound Window Address Translator

This block sits on the outbound path between a local bus and a PCIe-style memory region. It turns a local address, taken as an offset into that region, into a 64-bit bus address. The region is cut into 32 windows of the same size. One shared size code sets that size: 1 MiB shifted left by the 3-bit code. The window a request falls in is the offset divided by the window size. The bus address is that window's programmed 64-bit base plus the remainder.

Software programs the block through a simple word-wide register port with single-cycle writes and combinational reads. Each window has a low base word and a high base word. Bit 0 of the low word enables that window. One bit in a control word turns translation on for the whole block. Software sets that bit with a read-modify-write, so the other control bits are kept and read back unchanged. A translation request gives its result on the clock edge after it is presented. The result is either a hit with the bus address or a miss with a zero address.

Top module: `ob_window_xlate`

## Requirements
- R1: After reset every register reads zero, and a translation request returns a miss.
- R2: Register map, word-aligned byte offsets. Control word at 0x004: 32 bits, read/write. Size code at 0x030: bits [2:0], upper bits read zero. Window n (0..31): low base word at 0x200 + 8*n and high base word at 0x204 + 8*n, both 32 bits, read/write. Any other offset reads zero, and writes to it change no register.
- R3: With size code c, a window spans 2^(20+c) bytes, and local offset A selects window A >> (20+c).
- R4: On a hit the bus address is {high word, low word with bit 0 forced to 0} + (A mod 2^(20+c)), a full 64-bit sum.
- R5: A window index of 32 or more is a miss, whatever any window holds.
- R6: A request that selects a window whose low-word bit 0 is 0 is a miss.
- R7: While control bit 1 is 0, every request misses. The other control bits have no effect on translation.
- R8: A request presented on one clock edge yields valid on the next edge. Valid is low in cycles with no request, and a miss drives a bus address of zero.
- R9: A register write on an edge is seen by a request presented on the next edge, but not by a request presented on the same edge.
- R10: A carry out of the low 32 bits of the sum propagates into the high 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| xl_vld_i | input | 1 | Translation request |
| xl_addr_i | input | 32 | Local offset into the outbound region |
| xl_vld_o | output | 1 | Translation result valid |
| xl_hit_o | output | 1 | Result is a hit |
| xl_bus_addr_o | output | 64 | Translated bus address, zero on miss |

## Verification
The bound checker watches on every cycle the parts that depend only on timing and on the gating terms. These are: valid following a request by one edge, the quiet outputs after reset, zero address on a miss, no hit while the global enable is off, and no hit for an out-of-range index. The actual address arithmetic can only be shown by the bench's directed scenarios. These cover the base-plus-remainder sum at several size codes, the carry into the high word, the per-window enable, register readback and unmapped offsets, and the one-edge visibility of a register write.

// File: rtl/ob_window_xlate.sv
module ob_window_xlate #(
  parameter int NUM_WIN   = 32,
  parameter int LADDR_W   = 32,
  parameter int REG_AW    = 12,
  parameter int SZ_W      = 3,
  parameter int MIN_SHIFT = 20,
  parameter int XEN_BIT   = 1,
  parameter logic [11:0] CTL_OFS  = 12'h004,
  parameter logic [11:0] SIZE_OFS = 12'h030,
  parameter logic [11:0] WIN_OFS  = 12'h200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               xl_vld_i,
  input  logic [LADDR_W-1:0] xl_addr_i,
  output logic               xl_vld_o,
  output logic               xl_hit_o,
  output logic [63:0]        xl_bus_addr_o
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int SH_W  = 8;
  localparam logic [REG_AW-1:0]  NWIN_RA = REG_AW'(NUM_WIN);
  localparam logic [LADDR_W-1:0] NWIN_LA = LADDR_W'(NUM_WIN);

  logic [31:0]     ctl_q;
  logic [SZ_W-1:0] sz_q;
  logic [31:0]     lo_q [NUM_WIN];
  logic [31:0]     hi_q [NUM_WIN];

  logic              aligned, in_win, hi_sel;
  logic [REG_AW-1:0] win_rel;
  logic [IDX_W-1:0]  win_sel;

  assign aligned = reg_addr_i[1:0] == 2'b00;
  assign win_rel = reg_addr_i - REG_AW'(WIN_OFS);
  assign in_win  = aligned && (reg_addr_i >= REG_AW'(WIN_OFS)) && ((win_rel >> 3) < NWIN_RA);
  assign win_sel = win_rel[3 +: IDX_W];
  assign hi_sel  = win_rel[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sz_q  <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (reg_wr_i && aligned) begin
      if (reg_addr_i == REG_AW'(CTL_OFS))
        ctl_q <= reg_wdata_i;
      else if (reg_addr_i == REG_AW'(SIZE_OFS))
        sz_q <= reg_wdata_i[SZ_W-1:0];
      else if (in_win) begin
        if (hi_sel) hi_q[win_sel] <= reg_wdata_i;
        else        lo_q[win_sel] <= reg_wdata_i;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      if (reg_addr_i == REG_AW'(CTL_OFS))
        reg_rdata_o = ctl_q;
      else if (reg_addr_i == REG_AW'(SIZE_OFS))
        reg_rdata_o = {{(32-SZ_W){1'b0}}, sz_q};
      else if (in_win)
        reg_rdata_o = hi_sel ? hi_q[win_sel] : lo_q[win_sel];
    end
  end

  logic [SH_W-1:0]    sh;
  logic [LADDR_W-1:0] idx_full, ofs;
  logic [IDX_W-1:0]   wsel;
  logic [31:0]        lo_w;
  logic               hit_d;
  logic [63:0]        sum;

  assign sh       = SH_W'(MIN_SHIFT) + SH_W'(sz_q);
  assign idx_full = xl_addr_i >> sh;
  assign ofs      = xl_addr_i & ~({LADDR_W{1'b1}} << sh);
  assign wsel     = idx_full[IDX_W-1:0];
  assign lo_w     = lo_q[wsel];
  assign hit_d    = ctl_q[XEN_BIT] && (idx_full < NWIN_LA) && lo_w[0];
  assign sum      = {hi_q[wsel], lo_w[31:1], 1'b0} + 64'(ofs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_vld_o      <= 1'b0;
      xl_hit_o      <= 1'b0;
      xl_bus_addr_o <= '0;
    end else begin
      xl_vld_o      <= xl_vld_i;
      xl_hit_o      <= xl_vld_i && hit_d;
      xl_bus_addr_o <= (xl_vld_i && hit_d) ? sum : '0;
    end
  end
endmodule

// File: rtl/ob_window_xlate_chk.sv
module ob_window_xlate_chk #(
  parameter int NUM_WIN   = 32,
  parameter int LADDR_W   = 32,
  parameter int SZ_W      = 3,
  parameter int MIN_SHIFT = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xl_vld_i,
  input logic [LADDR_W-1:0] xl_addr_i,
  input logic               xl_vld_o,
  input logic               xl_hit_o,
  input logic [63:0]        xl_bus_addr_o,
  input logic               xen,
  input logic [SZ_W-1:0]    size_code
);
  logic [LADDR_W-1:0] idx_c;
  logic               out_of_range;
  assign idx_c        = xl_addr_i >> (MIN_SHIFT + int'(size_code));
  assign out_of_range = idx_c >= LADDR_W'(NUM_WIN);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!xl_vld_o && !xl_hit_o));
  p_vld_follow_r8: assert property (@(posedge clk) disable iff (!rst_n) xl_vld_i |=> xl_vld_o);
  p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) !xl_vld_i |=> !xl_vld_o);
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n) (xl_vld_o && !xl_hit_o) |-> xl_bus_addr_o == 64'd0);
  p_hit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n) xl_hit_o |-> xl_vld_o);
  p_global_off_r7: assert property (@(posedge clk) disable iff (!rst_n) (xl_vld_i && !xen) |=> !xl_hit_o);
  p_range_miss_r5: assert property (@(posedge clk) disable iff (!rst_n) (xl_vld_i && out_of_range) |=> !xl_hit_o);
endmodule

bind ob_window_xlate ob_window_xlate_chk #(
  .NUM_WIN(NUM_WIN), .LADDR_W(LADDR_W), .SZ_W(SZ_W), .MIN_SHIFT(MIN_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xl_vld_i(xl_vld_i), .xl_addr_i(xl_addr_i),
  .xl_vld_o(xl_vld_o), .xl_hit_o(xl_hit_o), .xl_bus_addr_o(xl_bus_addr_o),
  .xen(ctl_q[XEN_BIT]), .size_code(sz_q)
);

// File: tb/ob_window_xlate_tb_top.sv
module ob_window_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        xl_vld_i = 1'b0;
  logic [31:0] xl_addr_i = '0;
  logic        xl_vld_o, xl_hit_o;
  logic [63:0] xl_bus_addr_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ob_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .xl_vld_i(xl_vld_i),
    .xl_addr_i(xl_addr_i), .xl_vld_o(xl_vld_o), .xl_hit_o(xl_hit_o),
    .xl_bus_addr_o(xl_bus_addr_o)
  );

  function automatic logic [11:0] lo_ofs(int n); return 12'(12'h200 + 8 * n); endfunction
  function automatic logic [11:0] hi_ofs(int n); return 12'(12'h204 + 8 * n); endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr_i = a;
    #1;
    chk(tag, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic xl_chk(string tag, logic [31:0] a, logic exp_hit, logic [63:0] exp_addr);
    @(negedge clk);
    xl_vld_i = 1'b1; xl_addr_i = a;
    @(negedge clk);
    xl_vld_i = 1'b0;
    chk({tag, " vld"}, 64'(xl_vld_o), 64'd1);
    chk({tag, " hit"}, 64'(xl_hit_o), 64'(exp_hit));
    chk({tag, " addr"}, xl_bus_addr_o, exp_addr);
  endtask

  task automatic t_reset;
    chk("R1 vld in reset", 64'(xl_vld_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 ctl", 12'h004, 32'h0);
    rd_chk("R1 size", 12'h030, 32'h0);
    rd_chk("R1 lo0", lo_ofs(0), 32'h0);
    rd_chk("R1 hi31", hi_ofs(31), 32'h0);
    xl_chk("R1 xl after reset", 32'h0, 1'b0, 64'h0);
  endtask

  task automatic t_regmap;
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R2 ctl rw", 12'h004, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
    rd_chk("R2 size masked", 12'h030, 32'h7);
    wr(lo_ofs(5), 32'hA5A5_0F0F);
    wr(hi_ofs(5), 32'h1234_5678);
    rd_chk("R2 lo5", lo_ofs(5), 32'hA5A5_0F0F);
    rd_chk("R2 hi5", hi_ofs(5), 32'h1234_5678);
    wr(12'h300, 32'hDEAD_BEEF);
    rd_chk("R2 unmapped 0x300", 12'h300, 32'h0);
    wr(12'h100, 32'hCAFE_F00D);
    rd_chk("R2 unmapped 0x100", 12'h100, 32'h0);
    rd_chk("R2 lo0 untouched", lo_ofs(0), 32'h0);
    rd_chk("R2 hi31 untouched", hi_ofs(31), 32'h0);
    wr(lo_ofs(5), 32'h0); wr(hi_ofs(5), 32'h0);
    wr(12'h030, 32'h0); wr(12'h004, 32'h0);
  endtask

  task automatic t_basic;
    wr(lo_ofs(0), 32'h8000_0001); wr(hi_ofs(0), 32'h12);
    wr(lo_ofs(3), 32'h4000_0001);
    wr(12'h004, 32'h2);
    xl_chk("R4 win0", 32'h0001_2345, 1'b1, 64'h12_8001_2345);
    xl_chk("R3 win3 1MiB", 32'h0031_0000, 1'b1, 64'h4001_0000);
    xl_chk("R6 win1 disabled", 32'h0010_0000, 1'b0, 64'h0);
  endtask

  task automatic t_size;
    wr(12'h030, 32'h2);
    xl_chk("R3 win3 4MiB", 32'h00C0_0004, 1'b1, 64'h4000_0004);
    xl_chk("R3 4MiB into win1 disabled", 32'h0050_0000, 1'b0, 64'h0);
    xl_chk("R3 4MiB stays win0", 32'h0030_0000, 1'b1, 64'h12_8030_0000);
    wr(12'h030, 32'h0);
  endtask

  task automatic t_range;
    xl_chk("R5 index 32", 32'h0200_0000, 1'b0, 64'h0);
    wr(lo_ofs(31), 32'h1); wr(hi_ofs(31), 32'h7);
    xl_chk("R5 index 31", 32'h01F0_0000, 1'b1, 64'h7_0000_0000);
    wr(12'h030, 32'h7);
    xl_chk("R3 128MiB top", 32'hFFFF_FFFF, 1'b1, 64'h7_07FF_FFFF);
    xl_chk("R3 128MiB win0", 32'h0400_0000, 1'b1, 64'h12_8400_0000);
    wr(12'h030, 32'h0);
  endtask

  task automatic t_global;
    wr(12'h004, 32'hFFFF_FFFD);
    xl_chk("R7 global off", 32'h0000_0010, 1'b0, 64'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    xl_chk("R7 other bits set", 32'h0000_0010, 1'b1, 64'h12_8000_0010);
    wr(12'h004, 32'h2);
  endtask

  task automatic t_carry;
    wr(lo_ofs(2), 32'hFFFF_0001); wr(hi_ofs(2), 32'h1);
    xl_chk("R10 carry", 32'h0028_0000, 1'b1, 64'h2_0007_0000);
  endtask

  task automatic t_timing;
    wr(hi_ofs(4), 32'h5);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = lo_ofs(4); reg_wdata_i = 32'h1;
    xl_vld_i = 1'b1; xl_addr_i = 32'h0040_0000;
    @(negedge clk);
    reg_wr_i = 1'b0;
    chk("R9 same-edge sees old", 64'(xl_hit_o), 64'd0);
    @(negedge clk);
    xl_vld_i = 1'b0;
    chk("R9 next-edge sees new", 64'(xl_hit_o), 64'd1);
    chk("R9 next-edge addr", xl_bus_addr_o, 64'h5_0000_0000);
    @(negedge clk);
    chk("R8 idle vld low", 64'(xl_vld_o), 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_regmap;
    t_basic;
    t_size;
    t_range;
    t_global;
    t_carry;
    t_timing;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule